// File: doc/BRIEF.md
# MII Management Command Unit

This block gives a host a small register window for PHY management, with no serial management line behind it. The host programs a PHY address and a register address, writes transmit data, issues write or read commands, and reads back the returned data and a link-fail flag. One PHY is modelled internally at a fixed address. It holds sixteen 16-bit registers with their power-on values, a soft reset through the control register, read-only status and identity registers, and link-dependent bits that follow the `link_up` input.

Every command completes at the clock edge on which it is written, so no busy flag exists. The host reads back through a combinational mux selected by `host_addr`. Host register map (index on `host_addr`): 0 address, 1 command, 2 transmit data, 3 read data (read-only), 4 status (read-only). Other indices read 0.

Top module: `mii_mgmt_unit`

## Requirements
- R1: After reset every host register reads 0. The PHY file holds control 0x1000, status 0x7848, identifier-1 0x2000, identifier-2 0x5C90, advertisement 0x01E1 (index 4), and 0 elsewhere. The internal link state starts down, so link-partner ability (index 5) is 0.
- R2: The address register keeps the register address in bits 12:8 and the PHY address in bits 4:0. It reads back with all other bits zero.
- R3: A write to the command register with bit 1 set loads the selected PHY register into read data at that edge. Register addresses 16 to 31 read as 0.
- R4: Only PHY address 1 is populated. A read command to any other address loads 0xFFFF, and a write to any other address changes nothing.
- R5: A write to the transmit data register stores it and, when the PHY address is 1, writes the same value to the selected PHY register at once.
- R6: Command bit 2 writes the stored transmit data to the selected PHY register. When bits 2 and 1 are set together, the read returns the freshly written value.
- R7: A read command copies the link-down state (1 = down) into status bit 0. Host writes to the status and read-data registers have no effect.
- R8: A PHY write to the control register (index 0) with bit 15 set restores the whole PHY file to its reset values instead of storing the value. PHY writes to indices 1, 2 and 3, and to addresses 16 and above, are ignored.
- R9: When `link_up` rises, PHY status bit 2 is set and 0x01E1 is ORed into the link-partner register. When it falls, bit 2 is cleared and the link-partner register is ANDed with 0x01FF. The effect is visible after one clock edge.
- R10: While command bit 0 (scan) is stored as 1, each change of `link_up` writes the new link-down state into status bit 0. This takes priority over a read command in the same cycle.
- R11: When a host PHY write and a link change fall on the same edge, the host effect (including a soft reset) is applied first and the link adjustment after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` |
| link_up | input | 1 | Current link state, 1 = up |

## Verification
A link change can coincide with a host PHY write to the link-partner register, with a control-register soft reset, or with a read command while scan is on. The bench provokes all three: it drives `link_up` at the same negative edge as the host write, both in directed cases and on random cycles during the random run. Each result is judged against a bench model that applies the host effect first and the link adjustment second. The result is read back through later read commands.

// File: rtl/mii_mgmt_unit.sv
module mii_mgmt_unit #(
  parameter int PHY_ADDR = 1,
  parameter int NREG     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [2:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic        link_up
);
  localparam int IW = $clog2(NREG);
  localparam logic [4:0] PHY5 = 5'(PHY_ADDR);
  localparam logic [5:0] NREG6 = 6'(NREG);
  localparam logic [2:0] A_ADR = 3'd0, A_CMD = 3'd1, A_TX = 3'd2, A_RX = 3'd3, A_ST = 3'd4;

  logic [4:0]  pa_q, ra_q;
  logic [2:0]  cmd_q;
  logic [15:0] tx_q, rx_q;
  logic        lf_q, link_q;
  logic [15:0] file [NREG];
  logic [15:0] wfile [NREG];
  logic [15:0] nfile [NREG];

  function automatic logic [15:0] rst_val(input int i, input logic lnk);
    case (i)
      0: rst_val = 16'h1000;
      1: rst_val = 16'h7848 | {13'd0, lnk, 2'd0};
      2: rst_val = 16'h2000;
      3: rst_val = 16'h5C90;
      4: rst_val = 16'h01E1;
      5: rst_val = lnk ? 16'h01E1 : 16'h0000;
      default: rst_val = 16'h0000;
    endcase
  endfunction

  wire        here     = (pa_q == PHY5);
  wire        in_range = ({1'b0, ra_q} < NREG6);
  wire        rd_cmd   = host_we && host_addr == A_CMD && host_wdata[1];
  wire        phy_wr   = host_we && ((host_addr == A_CMD && host_wdata[2]) || host_addr == A_TX);
  wire [15:0] wval     = (host_addr == A_TX) ? host_wdata : tx_q;
  wire        link_chg = (link_up != link_q);

  always_comb begin
    wfile = file;
    if (phy_wr && here && in_range) begin
      if (ra_q == 5'd0) begin
        if (wval[15]) begin
          for (int i = 0; i < NREG; i++) wfile[i] = rst_val(i, link_q);
        end else begin
          wfile[0] = wval;
        end
      end else if (ra_q > 5'd3) begin
        wfile[ra_q[IW-1:0]] = wval;
      end
    end
    nfile = wfile;
    if (link_chg) begin
      if (link_up) begin
        nfile[1][2] = 1'b1;
        nfile[5]    = wfile[5] | 16'h01E1;
      end else begin
        nfile[1][2] = 1'b0;
        nfile[5]    = wfile[5] & 16'h01FF;
      end
    end
  end

  wire [15:0] rd_val = !here ? 16'hFFFF : (in_range ? wfile[ra_q[IW-1:0]] : 16'h0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q   <= '0;
      ra_q   <= '0;
      cmd_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      lf_q   <= 1'b0;
      link_q <= 1'b0;
      for (int i = 0; i < NREG; i++) file[i] <= rst_val(i, 1'b0);
    end else begin
      file   <= nfile;
      link_q <= link_up;
      if (host_we) begin
        case (host_addr)
          A_ADR: begin
            ra_q <= host_wdata[12:8];
            pa_q <= host_wdata[4:0];
          end
          A_CMD: begin
            cmd_q <= host_wdata[2:0];
            if (host_wdata[1]) rx_q <= rd_val;
          end
          A_TX: tx_q <= host_wdata;
          default: ;
        endcase
      end
      if (link_chg && cmd_q[0]) lf_q <= ~link_up;
      else if (rd_cmd)          lf_q <= ~link_q;
    end
  end

  always_comb begin
    case (host_addr)
      A_ADR:   host_rdata = {3'd0, ra_q, 3'd0, pa_q};
      A_CMD:   host_rdata = {13'd0, cmd_q};
      A_TX:    host_rdata = tx_q;
      A_RX:    host_rdata = rx_q;
      A_ST:    host_rdata = {15'd0, lf_q};
      default: host_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/mii_mgmt_unit_chk.sv
module mii_mgmt_unit_chk #(
  parameter int PHY_ADDR = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [2:0]  host_addr,
  input logic [15:0] host_wdata,
  input logic        link_up,
  input logic        link_q,
  input logic [4:0]  pa_q,
  input logic [2:0]  cmd_q,
  input logic [15:0] tx_q,
  input logic [15:0] rx_q,
  input logic        lf_q,
  input logic [15:0] st_w,
  input logic [15:0] lpa_w
);
  localparam logic [4:0] PHY5 = 5'(PHY_ADDR);

  p_absent_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_addr == 3'd1 && host_wdata[1] && pa_q != PHY5 |=> rx_q == 16'hFFFF);

  p_tx_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_we && host_addr == 3'd2 |=> tx_q == $past(host_wdata));

  p_status_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && host_addr == 3'd1 && host_wdata[1]) && !(cmd_q[0] && link_up != link_q)
    |=> $stable(lf_q));

  p_link_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    link_up && !link_q |=> st_w[2] && ((lpa_w & 16'h01E1) == 16'h01E1));

  p_link_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up && link_q |=> !st_w[2] && lpa_w[15:9] == 7'd0);

  p_scan_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[0] && link_up != link_q |=> lf_q == !$past(link_up));
endmodule

bind mii_mgmt_unit mii_mgmt_unit_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .link_up(link_up), .link_q(link_q), .pa_q(pa_q),
  .cmd_q(cmd_q), .tx_q(tx_q), .rx_q(rx_q), .lf_q(lf_q),
  .st_w(file[1]), .lpa_w(file[5])
);

// File: tb/mii_mgmt_unit_tb.sv
`timescale 1ns/1ps
module mii_mgmt_unit_tb;
  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        link_up = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [4:0]  m_pa, m_ra;
  logic [2:0]  m_cmd;
  logic [15:0] m_tx, m_rx;
  logic        m_lf, m_link;
  logic [15:0] m_phy [16];
  logic        cur;

  mii_mgmt_unit u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .link_up(link_up)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_phy_reset();
    for (int i = 0; i < 16; i++) m_phy[i] = 16'h0;
    m_phy[0] = 16'h1000;
    m_phy[1] = 16'h7848 | {13'd0, m_link, 2'd0};
    m_phy[2] = 16'h2000;
    m_phy[3] = 16'h5C90;
    m_phy[4] = 16'h01E1;
    m_phy[5] = m_link ? 16'h01E1 : 16'h0;
  endtask

  task automatic m_phy_wr(input logic [15:0] v);
    if (m_ra < 5'd16) begin
      if (m_ra == 5'd0) begin
        if (v[15]) m_phy_reset();
        else m_phy[0] = v;
      end else if (m_ra > 5'd3) begin
        m_phy[m_ra[3:0]] = v;
      end
    end
  endtask

  function automatic logic [15:0] m_host(input int a);
    case (a)
      0: m_host = {3'd0, m_ra, 3'd0, m_pa};
      1: m_host = {13'd0, m_cmd};
      2: m_host = m_tx;
      3: m_host = m_rx;
      4: m_host = {15'd0, m_lf};
      default: m_host = 16'h0;
    endcase
  endfunction

  task automatic verify_host();
    for (int a = 0; a < 5; a++) begin
      host_addr = 3'(a);
      #1;
      case (a)
        0: chk("R2 address readback", host_rdata, m_host(a));
        1: chk("R6 command readback", host_rdata, m_host(a));
        2: chk("R5 tx data readback", host_rdata, m_host(a));
        3: chk("R3 read data", host_rdata, m_host(a));
        default: chk("R7 status", host_rdata, m_host(a));
      endcase
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d, input logic lnk);
    logic scan_old;
    @(negedge clk);
    host_we = we; host_addr = a; host_wdata = d; link_up = lnk;
    scan_old = m_cmd[0];
    if (we) begin
      case (a)
        3'd0: begin m_ra = d[12:8]; m_pa = d[4:0]; end
        3'd1: begin
          m_cmd = d[2:0];
          if (d[2] && m_pa == 5'd1) m_phy_wr(m_tx);
          if (d[1]) begin
            m_rx = (m_pa != 5'd1) ? 16'hFFFF : (m_ra < 5'd16 ? m_phy[m_ra[3:0]] : 16'h0);
            m_lf = !m_link;
          end
        end
        3'd2: begin m_tx = d; if (m_pa == 5'd1) m_phy_wr(d); end
        default: ;
      endcase
    end
    if (lnk != m_link) begin
      if (lnk) begin m_phy[1][2] = 1'b1; m_phy[5] = m_phy[5] | 16'h01E1; end
      else     begin m_phy[1][2] = 1'b0; m_phy[5] = m_phy[5] & 16'h01FF; end
      if (scan_old) m_lf = !lnk;
    end
    m_link = lnk;
    cur = lnk;
    @(posedge clk);
    #1;
    host_we = 1'b0;
    verify_host();
  endtask

  task automatic phy_rd(input logic [4:0] ra, input logic [15:0] exp, input string tag);
    step(1'b1, 3'd0, {3'd0, ra, 3'd0, 5'd1}, cur);
    step(1'b1, 3'd1, 16'h0002, cur);
    host_addr = 3'd3;
    #1;
    chk(tag, host_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    m_pa = 0; m_ra = 0; m_cmd = 0; m_tx = 0; m_rx = 0; m_lf = 0; m_link = 0; cur = 0;
    m_phy_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    verify_host();
    for (int a = 0; a < 8; a++) begin
      host_addr = 3'(a);
      #1;
      chk("R1 host reg reset", host_rdata, 16'h0);
    end

    phy_rd(5'd0, 16'h1000, "R1 control reset");
    phy_rd(5'd1, 16'h7848, "R1 status reset");
    phy_rd(5'd2, 16'h2000, "R1 id1 reset");
    phy_rd(5'd3, 16'h5C90, "R1 id2 reset");
    phy_rd(5'd4, 16'h01E1, "R1 advert reset");
    phy_rd(5'd5, 16'h0000, "R1 partner reset");
    phy_rd(5'd20, 16'h0000, "R3 out-of-range read");

    step(1'b0, 3'd0, 16'h0, 1'b1);
    phy_rd(5'd1, 16'h784C, "R9 status link up");
    phy_rd(5'd5, 16'h01E1, "R9 partner link up");
    host_addr = 3'd4; #1; chk("R7 link fail after read up", host_rdata, 16'h0);

    step(1'b1, 3'd0, {3'd0, 5'd6, 3'd0, 5'd3}, cur);
    step(1'b1, 3'd1, 16'h0002, cur);
    host_addr = 3'd3; #1; chk("R4 absent phy reads ones", host_rdata, 16'hFFFF);
    step(1'b1, 3'd2, 16'hBEEF, cur);
    phy_rd(5'd6, 16'h0000, "R4 absent phy write ignored");

    step(1'b1, 3'd2, 16'h1234, cur);
    phy_rd(5'd6, 16'h1234, "R5 tx write-through");

    step(1'b1, 3'd0, {3'd0, 5'd7, 3'd0, 5'd1}, cur);
    step(1'b1, 3'd1, 16'h0006, cur);
    host_addr = 3'd3; #1; chk("R6 write then read", host_rdata, 16'h1234);

    step(1'b1, 3'd0, {3'd0, 5'd2, 3'd0, 5'd1}, cur);
    step(1'b1, 3'd2, 16'hFFFF, cur);
    phy_rd(5'd2, 16'h2000, "R8 id write ignored");
    step(1'b1, 3'd0, {3'd0, 5'd18, 3'd0, 5'd1}, cur);
    step(1'b1, 3'd2, 16'h5555, cur);
    phy_rd(5'd18, 16'h0000, "R8 high address write ignored");
    step(1'b1, 3'd0, {3'd0, 5'd0, 3'd0, 5'd1}, cur);
    step(1'b1, 3'd2, 16'h0140, cur);
    phy_rd(5'd0, 16'h0140, "R8 control stores");
    step(1'b1, 3'd2, 16'h8000, cur);
    phy_rd(5'd0, 16'h1000, "R8 soft reset control");
    phy_rd(5'd7, 16'h0000, "R8 soft reset clears file");
    phy_rd(5'd1, 16'h784C, "R8 soft reset keeps link bit");

    step(1'b1, 3'd4, 16'h0001, cur);
    host_addr = 3'd4; #1; chk("R7 status not writable", host_rdata, 16'h0);
    step(1'b1, 3'd3, 16'hAAAA, cur);
    host_addr = 3'd3; #1; chk("R7 read data not writable", host_rdata, 16'h784C);
    step(1'b0, 3'd0, 16'h0, 1'b0);
    step(1'b1, 3'd1, 16'h0002, cur);
    host_addr = 3'd4; #1; chk("R7 link fail after read down", host_rdata, 16'h1);

    step(1'b1, 3'd1, 16'h0001, cur);
    step(1'b0, 3'd0, 16'h0, 1'b1);
    host_addr = 3'd4; #1; chk("R10 scan link up", host_rdata, 16'h0);
    step(1'b1, 3'd1, 16'h0003, 1'b0);
    host_addr = 3'd4; #1; chk("R10 scan beats read", host_rdata, 16'h1);

    step(1'b1, 3'd0, {3'd0, 5'd5, 3'd0, 5'd1}, cur);
    step(1'b1, 3'd2, 16'hFE00, 1'b1);
    phy_rd(5'd5, 16'hFFE1, "R11 write then link up");
    step(1'b1, 3'd2, 16'hFFFF, 1'b0);
    phy_rd(5'd5, 16'h01FF, "R11 write then link down");
    step(1'b1, 3'd0, {3'd0, 5'd0, 3'd0, 5'd1}, cur);
    step(1'b1, 3'd2, 16'h8000, 1'b1);
    phy_rd(5'd5, 16'h01E1, "R11 soft reset then link up");
    phy_rd(5'd1, 16'h784C, "R11 soft reset status link up");

    for (int n = 0; n < 4000; n++) begin
      int op;
      logic lnk;
      logic [15:0] d;
      op  = int'($urandom % 10);
      lnk = ($urandom % 6 == 0) ? ~cur : cur;
      d   = 16'($urandom);
      case (op)
        0: begin
          logic [4:0] pa, ra;
          pa = ($urandom % 4 == 0) ? 5'($urandom) : 5'd1;
          ra = ($urandom % 5 == 0) ? 5'($urandom) : 5'($urandom % 8);
          step(1'b1, 3'd0, {d[15:13], ra, d[7:5], pa}, lnk);
        end
        1, 2: begin
          if ($urandom % 8 != 0) d[15] = 1'b0;
          step(1'b1, 3'd2, d, lnk);
        end
        3, 4, 5: step(1'b1, 3'd1, {13'd0, d[2:0]}, lnk);
        6: step(1'b1, 3'(3 + $urandom % 5), d, lnk);
        default: step(1'b0, 3'd0, d, lnk);
      endcase
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule